// File: doc/BRIEF.md
# Sequential-Access Configuration Register Bank

This block holds ten byte-wide settings, numbered 1 to 10, for a buffering device that has separate write and read clocks. Software has no address lines to reach them. Instead, it pulls the bank-select strobe low. Each qualified write-clock edge then stores the low input byte into the next register in turn. Each qualified read-clock edge fetches the next register in turn onto the low byte of a wide output word. Each of the two walks has its own pointer. A pointer runs from 1 up to 10 and then starts again at 1. Raising the bank-select strobe sends both pointers back to 1.

A slow serial port works alongside the parallel path and can only write. While the serial enable is low, every rising edge of the serial clock shifts in one bit. A frame is twelve bits long: a 4-bit register number followed by 8 data bits, each field sent most significant bit first. The frame takes effect on its twelfth bit. The write-clock domain samples the serial pins through a short synchronizer. As a result, a serial write lands on a write-clock edge, just as a parallel write does.

A master reset loads the default values into every register. A partial reset only rewinds the pointers and discards any serial frame or read that is still in progress. The top bit of register 10 is also driven straight out, as the flag that says which clock is faster.

Top module: `cfg_regbank`

## Requirements
- R1: After master reset the registers hold 0x00, except register 4 and register 7, which hold 0x7F, and register 10, which holds 0x80.
- R2: On a write-clock rising edge with bank_sel_n low, wr_en_n low and ser_en_n high, wr_byte is stored in the register that the write pointer selects. The write pointer then advances. It starts at 1.
- R3: After writing register 10, the write pointer returns to register 1.
- R4: On a read-clock rising edge with bank_sel_n low, rd_en_n low and ser_en_n high, the register that the read pointer selects is fetched. The read pointer then advances from 1 to 10 and wraps back to 1.
- R5: Read data appears on rd_word[7:0] with rd_vld high. If the fetch edge is edge k, the data appears after read-clock edge k+3, so the result comes on the fourth edge counted from the fetch. rd_word[35:8] is always zero. When rd_vld is low, rd_word is zero.
- R6: A rising edge on bank_sel_n, as seen by each clock domain, sets that domain's pointer back to register 1.
- R7: While ser_en_n is low, each ser_clk rise shifts in ser_din. Each ser_clk level must be held for at least two write-clock cycles. On the twelfth bit, bits 11..8 of the frame give the register number and bits 7..0 give the data, and the data is written. Frames with a register number of 0 or of 11 to 15 change nothing. A frame that ser_en_n interrupts by going high is discarded.
- R8: While ser_en_n is low, parallel writes and parallel reads are blocked and both pointers hold their values. This is the illegal combination.
- R9: If a serial frame and a parallel write complete on the same write-clock edge, both take effect. If both target the same register, the serial data is kept.
- R10: Master reset restores every default value, sets both pointers to 1, discards any partial serial frame and clears the read pipeline.
- R11: Partial reset sets both pointers to 1, discards any partial serial frame and any read still in the pipeline, and leaves every register value unchanged.
- R12: fast_wr_clk always equals bit 7 of register 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mst_rst | input | 1 | Master reset, synchronous, active high, sampled by both clocks |
| part_rst | input | 1 | Partial reset, synchronous, active high, sampled by both clocks |
| bank_sel_n | input | 1 | Low selects the register bank for parallel access |
| wr_en_n | input | 1 | Parallel write enable, active low |
| rd_en_n | input | 1 | Parallel read enable, active low |
| wr_byte | input | 8 | Parallel write data |
| ser_clk | input | 1 | Serial shift clock, sampled by wr_clk |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_din | input | 1 | Serial data, MSB first |
| rd_word | output | 36 | Read data, register byte in bits 7..0 |
| rd_vld | output | 1 | High while rd_word carries a fetched register |
| fast_wr_clk | output | 1 | Bit 7 of register 10 |

## Verification
Two functions can act on the same write-clock edge: the completion of a serial frame and a parallel write. The bench provokes this by raising ser_clk for the twelfth bit. It then raises ser_en_n before the synchronizer can carry it along, and drives a single parallel write on the third write-clock edge after the serial clock rise, which is the edge where the synchronized rise is acted on. It does this once with both paths aimed at register 1, and once with the serial frame aimed at register 6. It then reads the whole bank back in parallel. The serial byte must win in register 1 in the first run, and both bytes must be present in the second.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int NREG       = 10;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 4;
    localparam int FRAME_BITS = ADDR_W + REG_W;

    typedef logic [ADDR_W-1:0]            addr_t;
    typedef logic [REG_W-1:0]             byte_t;
    typedef logic [NREG-1:0][REG_W-1:0]   bank_t;

    // one committed serial frame
    typedef struct packed {
        logic  vld;
        addr_t addr;
        byte_t data;
    } ser_wr_t;

    // one beat travelling down the read pipeline
    typedef struct packed {
        logic  vld;
        byte_t data;
    } rd_beat_t;

    // reset value of register number idx (1-based)
    function automatic byte_t reg_default(input int unsigned idx);
        byte_t v;
        if (idx == 4 || idx == 7)
            v = 8'h7F;
        else if (idx == NREG)
            v = 8'h80;
        else
            v = 8'h00;
        return v;
    endfunction

    // sequential pointer step 1..NREG with wrap
    function automatic addr_t addr_next(input addr_t a);
        addr_t n;
        if (a == addr_t'(NREG))
            n = addr_t'(1);
        else
            n = a + addr_t'(1);
        return n;
    endfunction

    function automatic logic addr_ok(input addr_t a);
        return (a != '0) && (a <= addr_t'(NREG));
    endfunction

endpackage

// File: rtl/cfg_ser_rx.sv
module cfg_ser_rx
    import cfg_bank_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic    clk,
    input  logic    mst_rst,
    input  logic    part_rst,
    input  logic    ser_clk,
    input  logic    ser_en_n,
    input  logic    ser_din,
    output ser_wr_t commit
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic sck;
        logic en_n;
        logic dat;
    } ser_pins_t;

    localparam ser_pins_t PINS_IDLE = '{sck: 1'b0, en_n: 1'b1, dat: 1'b0};

    ser_pins_t                  sync_q [SYNC_DEPTH];
    ser_pins_t                  smp;
    logic                       sck_prev;
    logic                       rise;
    logic [CNT_W-1:0]           bit_cnt;
    logic [FRAME_BITS-2:0]      shreg;
    logic [FRAME_BITS-1:0]      frame;
    logic                       last_bit;
    logic                       rst;

    assign rst = mst_rst | part_rst;

    // synchronizer chain for the three serial pins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_DEPTH; s++)
                sync_q[s] <= PINS_IDLE;
        end else begin
            sync_q[0] <= '{sck: ser_clk, en_n: ser_en_n, dat: ser_din};
            for (int s = 1; s < SYNC_DEPTH; s++)
                sync_q[s] <= sync_q[s-1];
        end
    end

    assign smp      = sync_q[SYNC_DEPTH-1];
    assign rise     = smp.sck & ~sck_prev;
    assign frame    = {shreg, smp.dat};
    assign last_bit = rise & ~smp.en_n & (bit_cnt == CNT_W'(FRAME_BITS - 1));

    always_comb begin
        commit.addr = frame[FRAME_BITS-1 -: ADDR_W];
        commit.data = frame[REG_W-1:0];
        commit.vld  = last_bit & addr_ok(frame[FRAME_BITS-1 -: ADDR_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
        end else begin
            sck_prev <= smp.sck;
            if (smp.en_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= frame[FRAME_BITS-2:0];
                if (bit_cnt == CNT_W'(FRAME_BITS - 1))
                    bit_cnt <= '0;
                else
                    bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cfg_wr_bank.sv
module cfg_wr_bank
    import cfg_bank_pkg::*;
(
    input  logic    clk,
    input  logic    mst_rst,
    input  logic    part_rst,
    input  logic    bank_sel_n,
    input  logic    ser_en_n,
    input  logic    wr_en_n,
    input  byte_t   wr_byte,
    input  ser_wr_t ser_wr,
    output bank_t   regs,
    output addr_t   wptr
);
    logic sel_q;
    logic par_go;
    logic sel_rise;

    assign par_go   = ~bank_sel_n & ~wr_en_n & ser_en_n;
    assign sel_rise = bank_sel_n & ~sel_q;

    always_ff @(posedge clk) begin
        if (mst_rst) begin
            for (int i = 0; i < NREG; i++)
                regs[i] <= reg_default(i + 1);
            wptr  <= addr_t'(1);
            sel_q <= 1'b1;
        end else if (part_rst) begin
            wptr  <= addr_t'(1);
            sel_q <= 1'b1;
        end else begin
            sel_q <= bank_sel_n;
            if (sel_rise)
                wptr <= addr_t'(1);
            else if (par_go)
                wptr <= addr_next(wptr);
            if (par_go)
                regs[wptr - addr_t'(1)] <= wr_byte;
            // serial commit last: it wins on a shared target
            if (ser_wr.vld)
                regs[ser_wr.addr - addr_t'(1)] <= ser_wr.data;
        end
    end

endmodule

// File: rtl/cfg_rd_pipe.sv
module cfg_rd_pipe
    import cfg_bank_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int RD_LAT = 4
) (
    input  logic              clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              bank_sel_n,
    input  logic              ser_en_n,
    input  logic              rd_en_n,
    input  bank_t             regs,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_vld,
    output addr_t             rptr
);
    rd_beat_t pipe [RD_LAT];
    logic     sel_q;
    logic     rd_go;
    logic     sel_rise;

    assign rd_go    = ~bank_sel_n & ~rd_en_n & ser_en_n;
    assign sel_rise = bank_sel_n & ~sel_q;

    always_ff @(posedge clk) begin
        if (mst_rst || part_rst) begin
            rptr  <= addr_t'(1);
            sel_q <= 1'b1;
            for (int g = 0; g < RD_LAT; g++)
                pipe[g] <= '0;
        end else begin
            sel_q <= bank_sel_n;
            if (sel_rise)
                rptr <= addr_t'(1);
            else if (rd_go)
                rptr <= addr_next(rptr);
            pipe[0].vld  <= rd_go;
            pipe[0].data <= rd_go ? regs[rptr - addr_t'(1)] : '0;
            for (int g = 1; g < RD_LAT; g++)
                pipe[g] <= pipe[g-1];
        end
    end

    assign rd_vld  = pipe[RD_LAT-1].vld;
    assign rd_word = DATA_W'(pipe[RD_LAT-1].data);

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_bank_pkg::*;
#(
    parameter int DATA_W     = 36,
    parameter int RD_LAT     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              bank_sel_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [7:0]        wr_byte,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    input  logic              ser_din,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_vld,
    output logic              fast_wr_clk
);
    ser_wr_t ser_wr;
    bank_t   reg_file;
    addr_t   wptr;
    addr_t   rptr;

    cfg_ser_rx #(.SYNC_DEPTH(SYNC_DEPTH)) u_ser (
        .clk      (wr_clk),
        .mst_rst  (mst_rst),
        .part_rst (part_rst),
        .ser_clk  (ser_clk),
        .ser_en_n (ser_en_n),
        .ser_din  (ser_din),
        .commit   (ser_wr)
    );

    cfg_wr_bank u_bank (
        .clk        (wr_clk),
        .mst_rst    (mst_rst),
        .part_rst   (part_rst),
        .bank_sel_n (bank_sel_n),
        .ser_en_n   (ser_en_n),
        .wr_en_n    (wr_en_n),
        .wr_byte    (wr_byte),
        .ser_wr     (ser_wr),
        .regs       (reg_file),
        .wptr       (wptr)
    );

    cfg_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
        .clk        (rd_clk),
        .mst_rst    (mst_rst),
        .part_rst   (part_rst),
        .bank_sel_n (bank_sel_n),
        .ser_en_n   (ser_en_n),
        .rd_en_n    (rd_en_n),
        .regs       (reg_file),
        .rd_word    (rd_word),
        .rd_vld     (rd_vld),
        .rptr       (rptr)
    );

    assign fast_wr_clk = reg_file[NREG-1][REG_W-1];

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
    import cfg_bank_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mst_rst,
    input logic              part_rst,
    input logic              bank_sel_n,
    input logic              ser_en_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic              ser_vld,
    input bank_t             regs,
    input addr_t             wptr,
    input addr_t             rptr,
    input logic [DATA_W-1:0] rd_word,
    input logic              rd_vld,
    input logic              fast_wr_clk
);
    // R3: write pointer stays inside 1..10
    a_r3_wptr_range: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (wptr >= addr_t'(1)) && (wptr <= addr_t'(NREG)));

    // R3: wrap after register 10
    a_r3_wptr_wrap: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (wptr == addr_t'(NREG) && !bank_sel_n && !wr_en_n && ser_en_n) |=> (wptr == addr_t'(1)));

    // R4: read pointer wrap after register 10
    a_r4_rptr_wrap: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
        (rptr == addr_t'(NREG) && !bank_sel_n && !rd_en_n && ser_en_n) |=> (rptr == addr_t'(1)));

    // R5: only the low byte is ever driven
    a_r5_upper_zero: assert property (@(posedge rd_clk) disable iff (mst_rst)
        rd_word[DATA_W-1:REG_W] == '0);

    // R5: idle output is zero
    a_r5_idle_zero: assert property (@(posedge rd_clk) disable iff (mst_rst)
        !rd_vld |-> (rd_word == '0));

    // R8: illegal combination leaves the bank untouched
    a_r8_blocked: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
        (!ser_en_n && !bank_sel_n && !wr_en_n && !ser_vld) |=> $stable(regs));

    // R10 and R12: master reset brings back defaults and the fast-clock flag
    a_r10_defaults: assert property (@(posedge wr_clk)
        mst_rst |=> (regs[3] == 8'h7F) && (regs[6] == 8'h7F) && (regs[0] == 8'h00) && fast_wr_clk);

    // R11: partial reset keeps register contents
    a_r11_keep: assert property (@(posedge wr_clk) disable iff (mst_rst)
        part_rst |=> $stable(regs));

    // R11: partial reset empties the read pipeline
    a_r11_rd_clear: assert property (@(posedge rd_clk) disable iff (mst_rst)
        part_rst |=> !rd_vld);

endmodule

bind cfg_regbank cfg_regbank_chk #(.DATA_W(DATA_W)) chk_i (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .mst_rst     (mst_rst),
    .part_rst    (part_rst),
    .bank_sel_n  (bank_sel_n),
    .ser_en_n    (ser_en_n),
    .wr_en_n     (wr_en_n),
    .rd_en_n     (rd_en_n),
    .ser_vld     (ser_wr.vld),
    .regs        (reg_file),
    .wptr        (wptr),
    .rptr        (rptr),
    .rd_word     (rd_word),
    .rd_vld      (rd_vld),
    .fast_wr_clk (fast_wr_clk)
);

// File: tb/cfg_regbank_tb_top.sv
module cfg_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD + 4;
    localparam int LAT        = 4;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        mst_rst, part_rst, bank_sel_n, wr_en_n, rd_en_n;
    logic [7:0]  wr_byte;
    logic        ser_clk, ser_en_n, ser_din;
    logic [35:0] rd_word;
    logic        rd_vld, fast_wr_clk;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    cfg_regbank dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .bank_sel_n(bank_sel_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .wr_byte(wr_byte),
        .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_din(ser_din),
        .rd_word(rd_word), .rd_vld(rd_vld), .fast_wr_clk(fast_wr_clk)
    );

    typedef struct {
        logic [7:0] data;
        int         due;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    int         rcyc     = 0;
    logic [7:0] mdl [1:10];
    int         wp = 1;
    int         rp = 1;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int nxt(input int p);
        return (p == 10) ? 1 : p + 1;
    endfunction

    task automatic load_defaults();
        for (int i = 1; i <= 10; i++)
            mdl[i] = (i == 4 || i == 7) ? 8'h7F : ((i == 10) ? 8'h80 : 8'h00);
        wp = 1;
        rp = 1;
    endtask

    // read-clock cycle counter for latency checks
    always @(posedge rd_clk) rcyc++;

    // monitor: pop and compare
    always @(negedge rd_clk) begin
        if (rd_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected read beat", {28'd0, rd_word}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rd_word[7:0] == e.data, e.tag, rd_word[7:0], e.data);
                chk(rcyc == e.due, "R5 read latency", rcyc, e.due);
                chk(rd_word[35:8] == 28'd0, "R5 upper bits", rd_word[35:8], 0);
            end
        end
    end

    task automatic raise_sel();
        @(negedge wr_clk) bank_sel_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        repeat (2) @(negedge rd_clk);
        wp = 1;
        rp = 1;
    endtask

    task automatic write_one(input logic [7:0] v);
        @(negedge wr_clk);
        bank_sel_n = 1'b0;
        wr_en_n    = 1'b0;
        wr_byte    = v;
        mdl[wp]    = v;
        wp         = nxt(wp);
        @(negedge wr_clk) wr_en_n = 1'b1;
    endtask

    task automatic read_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge rd_clk);
            bank_sel_n = 1'b0;
            rd_en_n    = 1'b0;
            e.data = mdl[rp];
            e.due  = rcyc + LAT;
            e.tag  = tag;
            exp_q.push_back(e);
            rp = nxt(rp);
        end
        @(negedge rd_clk) rd_en_n = 1'b1;
        repeat (LAT + 3) @(negedge rd_clk);
        chk(exp_q.size() == 0, {tag, " drained"}, exp_q.size(), 0);
    endtask

    task automatic ser_bit(input logic b);
        @(negedge wr_clk);
        ser_din  = b;
        ser_en_n = 1'b0;
        repeat (2) @(negedge wr_clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge wr_clk);
        ser_clk = 1'b0;
    endtask

    task automatic ser_frame(input logic [3:0] a, input logic [7:0] d);
        logic [11:0] f;
        f = {a, d};
        for (int i = 11; i >= 0; i--)
            ser_bit(f[i]);
        repeat (3) @(negedge wr_clk);
        ser_en_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        if (a >= 1 && a <= 10)
            mdl[a] = d;
    endtask

    // R9: serial commit and parallel write on the same write-clock edge
    task automatic collide(input logic [3:0] a, input logic [7:0] d, input logic [7:0] pv);
        logic [11:0] f;
        f = {a, d};
        for (int i = 11; i >= 1; i--)
            ser_bit(f[i]);
        @(negedge wr_clk);
        ser_din = f[0];
        repeat (2) @(negedge wr_clk);
        ser_clk = 1'b1;                      // edge A samples this
        @(negedge wr_clk) ser_en_n = 1'b1;   // before edge B
        @(negedge wr_clk);                   // before edge C
        bank_sel_n = 1'b0;
        wr_en_n    = 1'b0;
        wr_byte    = pv;
        @(negedge wr_clk);
        wr_en_n    = 1'b1;
        bank_sel_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge wr_clk);
        repeat (2) @(negedge rd_clk);
        mdl[1] = pv;
        mdl[a] = d;
        wp = 1;
        rp = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        mst_rst = 1'b1; part_rst = 1'b0; bank_sel_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        wr_byte = 8'h00; ser_clk = 1'b0; ser_en_n = 1'b1; ser_din = 1'b0;
        load_defaults();
        repeat (6) @(negedge wr_clk);
        mst_rst = 1'b0;
        @(negedge rd_clk);
        chk(rd_vld == 1'b0, "R5 reset rd_vld", rd_vld, 0);
        chk(rd_word == 36'd0, "R5 reset rd_word", rd_word, 0);
        chk(fast_wr_clk == 1'b1, "R12 reset fast flag", fast_wr_clk, 1);

        // R1 and R4: defaults, then wrap back to register 1
        read_n(11, "R1/R4 default readback");
        raise_sel();

        // R2 and R3: twelve writes, last two wrap onto registers 1 and 2
        for (int i = 1; i <= 12; i++)
            write_one(8'(8'h10 + i));
        raise_sel();
        read_n(10, "R2/R3 sequential write");
        raise_sel();

        // R6: pointer rewind on select rise
        write_one(8'hA1); write_one(8'hA2); write_one(8'hA3);
        raise_sel();
        write_one(8'hC3);
        raise_sel();
        read_n(2, "R6 read before rewind");
        raise_sel();
        read_n(1, "R6 read after rewind");
        raise_sel();

        // R8: illegal combination blocks both paths
        write_one(8'h5A);
        @(negedge wr_clk);
        ser_en_n = 1'b0; wr_en_n = 1'b0; wr_byte = 8'hEE;
        repeat (3) @(negedge wr_clk);
        wr_en_n = 1'b1; ser_en_n = 1'b1;
        write_one(8'h6B);
        @(negedge rd_clk);
        ser_en_n = 1'b0; bank_sel_n = 1'b0; rd_en_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        rd_en_n = 1'b1; ser_en_n = 1'b1;
        repeat (LAT + 2) @(negedge rd_clk);
        read_n(2, "R8 pointer held");
        raise_sel();

        // R7 and R12: serial frames, including out-of-range numbers
        ser_frame(4'd5, 8'hA5);
        ser_frame(4'd10, 8'h00);
        chk(fast_wr_clk == 1'b0, "R12 fast flag cleared", fast_wr_clk, 0);
        ser_frame(4'd0, 8'hFF);
        ser_frame(4'd11, 8'hFF);
        ser_frame(4'd15, 8'hFF);
        read_n(10, "R7 serial writes");
        raise_sel();

        // R9: collision on the same and on different registers
        collide(4'd1, 8'h3C, 8'hC3);
        collide(4'd6, 8'h66, 8'h99);
        read_n(10, "R9 collision result");
        raise_sel();

        // R11: partial reset
        write_one(8'h21); write_one(8'h22);
        for (int i = 0; i < 6; i++)
            ser_bit(i[0]);
        @(negedge wr_clk) part_rst = 1'b1;
        repeat (4) @(negedge wr_clk);
        part_rst = 1'b0; ser_en_n = 1'b1;
        wp = 1; rp = 1;
        repeat (2) @(negedge wr_clk);
        write_one(8'h77);
        ser_frame(4'd4, 8'h44);
        @(negedge rd_clk) rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1; part_rst = 1'b1;
        repeat (4) @(negedge wr_clk);
        part_rst = 1'b0;
        wp = 1; rp = 1;
        repeat (LAT + 3) @(negedge rd_clk);
        chk(exp_q.size() == 0, "R11 pipeline flushed", exp_q.size(), 0);
        read_n(10, "R11 contents kept");
        raise_sel();

        // R10: master reset restores defaults
        @(negedge wr_clk) mst_rst = 1'b1;
        repeat (6) @(negedge wr_clk);
        mst_rst = 1'b0;
        load_defaults();
        @(negedge wr_clk);
        chk(fast_wr_clk == 1'b1, "R10 fast flag restored", fast_wr_clk, 1);
        read_n(10, "R10 defaults restored");

        finish_run();
    end

endmodule